// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit is the host-side data and status half of a serial peripheral controller. It buffers outgoing words in an 8-deep, 32-bit transmit queue that the shift engine drains, and incoming words in an 8-deep, 32-bit receive queue that the shift engine fills. The host reaches it through a small word-addressed register window using single-cycle read and write strobes. Reading the receive-data location removes the word at the head of the receive queue.

A sticky status register records completion, service requests and error events. Each of these bits is cleared by writing 1 to it. An enable register selects which events raise the single interrupt line. Its bit order is shifted by one from the status bits because the status word keeps bit 0 for a live busy indication. Both queue fill levels are packed into one count register, and one threshold register sets the fill levels at which the service requests appear.

Register map (word addresses on `host_addr`): 0 status, 1 interrupt enable, 2 thresholds, 3 fill counts, 4 transmit data (write), 5 receive data (read, removes one word). Any other address reads as zero.

Top module: `spi_fifo_stat_unit`

## Requirements
- R1: After a synchronous reset both queues are empty and the count register reads 0. The enable register reads 0, the threshold register reads 0x44 (both thresholds 4), and `irq` is low.
- R2: Each queue holds 8 words of 32 bits and returns them in arrival order. The count register (address 3) carries the receive count in bits 3:0 and the transmit count in bits 7:4.
- R3: A host write to transmit data while the transmit queue holds 8 words is ignored, and the queue keeps its contents.
- R4: An engine push while the receive queue holds 8 words drops that word and sets status bit 5 (receive overflow).
- R5: An engine pop while the transmit queue is empty sets status bit 4 (transmit underflow).
- R6: Writing 1 to a status bit in 5:1 clears it, and writing 0 leaves it unchanged. If the event that sets a bit occurs in the same cycle as the clear, the bit stays set.
- R7: Status bit 0 reads the engine busy input directly, and writes do not affect it.
- R8: Status bit 1 (transfer done) is set by a done pulse from the engine and stays set until it is cleared.
- R9: Status bit 2 (transmit request) is set in every cycle where the transmit count is at or below the transmit threshold, which is threshold register bits 3:0.
- R10: Status bit 3 (receive request) is set in every cycle where the receive count is at or above the receive threshold, which is threshold register bits 7:4. It is also set by a done pulse while the receive queue is not empty.
- R11: `irq` is the OR of these pairs: enable bit 0 with status bit 1, enable bit 1 with status bit 2, enable bit 2 with status bit 3, enable bit 3 with status bit 4, and enable bit 4 with status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (removes a receive word at address 5) |
| host_addr | input | 3 | Register word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from address) |
| eng_busy | input | 1 | Engine is mid-transfer |
| eng_done | input | 1 | One-cycle transfer completion pulse |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_word | output | 32 | Head of the transmit queue |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_word | input | 32 | Received word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear that collides with a condition that is still true. In that case a status bit must read back as set even though the host has just cleared it. The stimulus reaches this case by programming thresholds so the transmit request condition stays true while the transmit queue is empty, then clearing the whole status word and reading it back. It then fills the queue past the threshold and shows that the same clear now takes effect. Overflow and underflow are reached by driving the engine push and pop strobes past the queue limits while the host side stays idle.

// File: rtl/sfsu_pkg.sv
package sfsu_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 3'd0,
        REG_INTEN  = 3'd1,
        REG_THRESH = 3'd2,
        REG_COUNT  = 3'd3,
        REG_TXDATA = 3'd4,
        REG_RXDATA = 3'd5
    } reg_sel_e;

    // Sticky events, packed so the struct lines up with status bits 5:1
    typedef struct packed {
        logic rx_of;
        logic tx_uf;
        logic rx_req;
        logic tx_req;
        logic done;
    } evt_t;

    localparam int EVT_W = $bits(evt_t);

    function automatic logic [WORD_W-1:0] pack_status(evt_t ev, logic busy);
        return WORD_W'({ev, busy});
    endfunction

endpackage

// File: rtl/sfsu_fifo.sv
module sfsu_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3/R4: a push into a full queue with no pop leaves the level unchanged
    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/sfsu_status.sv
module sfsu_status
    import sfsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             set_ev,
    input  evt_t             clr_ev,
    input  logic [EVT_W-1:0] inten,
    output evt_t             sticky,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) sticky <= '0;
        else     sticky <= (sticky & ~clr_ev) | set_ev;
    end

    assign irq = |(EVT_W'(sticky) & inten);

    // R6: an event in the same cycle as its clear leaves the bit set
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_ev.done |=> sticky.done);

    // R8: done holds until cleared
    a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
        (sticky.done && !clr_ev.done) |=> sticky.done);

    // R11: no enables, no interrupt
    a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (inten == '0) |-> !irq);

endmodule

// File: rtl/spi_fifo_stat_unit.sv
module spi_fifo_stat_unit
    import sfsu_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int TX_TH_INIT = 4,
    parameter int RX_TH_INIT = 4,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_tx_pop,
    output logic [WORD_W-1:0] eng_tx_word,
    output logic              eng_tx_avail,
    input  logic              eng_rx_push,
    input  logic [WORD_W-1:0] eng_rx_word,
    output logic              irq
);
    localparam int FLD = 4;

    logic [CW-1:0]     tx_cnt, rx_cnt, tx_th, rx_th;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_head;
    logic [EVT_W-1:0]  inten;
    evt_t              set_ev, clr_ev, sticky;
    logic              wr_tx, rd_rx;

    assign wr_tx = host_wr && (host_addr == REG_TXDATA);
    assign rd_rx = host_rd && (host_addr == REG_RXDATA);

    sfsu_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_txq (
        .clk(clk), .rst(rst), .push(wr_tx), .din(host_wdata), .pop(eng_tx_pop),
        .dout(eng_tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    sfsu_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rxq (
        .clk(clk), .rst(rst), .push(eng_rx_push), .din(eng_rx_word), .pop(rd_rx),
        .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    assign eng_tx_avail = !tx_empty;

    // Control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            inten <= '0;
            tx_th <= CW'(TX_TH_INIT);
            rx_th <= CW'(RX_TH_INIT);
        end else if (host_wr) begin
            if (host_addr == REG_INTEN) inten <= host_wdata[EVT_W-1:0];
            if (host_addr == REG_THRESH) begin
                tx_th <= host_wdata[CW-1:0];
                rx_th <= host_wdata[FLD +: CW];
            end
        end
    end

    // Event sources
    always_comb begin
        set_ev.done   = eng_done;
        set_ev.tx_req = (tx_cnt <= tx_th);
        set_ev.rx_req = (rx_cnt >= rx_th) || (eng_done && !rx_empty);
        set_ev.tx_uf  = eng_tx_pop && tx_empty;
        set_ev.rx_of  = eng_rx_push && rx_full;
        clr_ev = (host_wr && host_addr == REG_STATUS) ? evt_t'(host_wdata[EVT_W:1]) : '0;
    end

    sfsu_status u_stat (
        .clk(clk), .rst(rst), .set_ev(set_ev), .clr_ev(clr_ev),
        .inten(inten), .sticky(sticky), .irq(irq));

    // Read path
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            REG_STATUS: host_rdata = pack_status(sticky, eng_busy);
            REG_INTEN:  host_rdata = WORD_W'(inten);
            REG_THRESH: host_rdata = WORD_W'({FLD'(rx_th), FLD'(tx_th)});
            REG_COUNT:  host_rdata = WORD_W'({FLD'(tx_cnt), FLD'(rx_cnt)});
            REG_RXDATA: host_rdata = rx_empty ? '0 : rx_head;
            default:    host_rdata = '0;
        endcase
    end

    // R5: popping an empty transmit queue raises underflow
    a_r5_underflow_flag: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_pop && tx_empty) |=> sticky.tx_uf);

    // R4: pushing a full receive queue raises overflow
    a_r4_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_push && rx_full) |=> sticky.rx_of);

    // R3: a host write into a full transmit queue changes nothing
    a_r3_tx_full_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && tx_full && !eng_tx_pop) |=> (tx_cnt == CW'(DEPTH)));

endmodule

// File: tb/spi_fifo_stat_unit_test.sv
module spi_fifo_stat_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        host_wr = 0, host_rd = 0;
    logic [2:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        eng_busy = 0, eng_done = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic [31:0] eng_tx_word, eng_rx_word = 0;
    logic        eng_tx_avail, irq;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_stat_unit uut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic hw(logic [2:0] a, logic [31:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic hr(logic [2:0] a, bit pop, output logic [31:0] d);
        @(negedge clk); host_addr = a; #1 d = host_rdata;
        if (pop) begin host_rd = 1; @(negedge clk); host_rd = 0; end
    endtask

    task automatic epop(output logic [31:0] w);
        @(negedge clk); w = eng_tx_word; eng_tx_pop = 1;
        @(negedge clk); eng_tx_pop = 0;
    endtask

    task automatic epush(logic [31:0] w);
        @(negedge clk); eng_rx_word = w; eng_rx_push = 1;
        @(negedge clk); eng_rx_push = 0;
    endtask

    task automatic edone();
        @(negedge clk); eng_done = 1;
        @(negedge clk); eng_done = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        hr(3, 0, d); check("R1 count after reset", d, 0);
        hr(1, 0, d); check("R1 inten after reset", d, 0);
        hr(2, 0, d); check("R1 thresh after reset", d, 32'h44);
        check("R1 irq after reset", irq, 0);
        hr(0, 0, d); check("R9 tx request on empty queue", d, 32'h04);
    endtask

    task automatic t_tx();
        logic [31:0] d, w;
        do_reset();
        for (int i = 0; i < 3; i++) hw(4, 32'hA000_0000 + i);
        hr(3, 0, d); check("R2 tx count field", d, 32'h30);
        for (int i = 3; i < 9; i++) hw(4, 32'hA000_0000 + i);
        hr(3, 0, d); check("R3 tx count capped at 8", d, 32'h80);
        for (int i = 0; i < 8; i++) begin
            epop(w); check("R2 tx word order", w, 32'hA000_0000 + i);
        end
        check("R3 tx queue empty after 8 pops", eng_tx_avail, 0);
        epop(w);
        hr(0, 0, d); check("R5 underflow flag", d, 32'h14);
        hw(0, 32'h10);
        hr(0, 0, d); check("R6 w1c clears only bit 4", d, 32'h04);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        do_reset();
        for (int i = 0; i < 9; i++) epush(32'hB000_0000 + i);
        hr(3, 0, d); check("R2 rx count field", d, 32'h08);
        hr(0, 0, d); check("R4 overflow with requests", d, 32'h2C);
        for (int i = 0; i < 8; i++) begin
            hr(5, 1, d); check("R4 rx word order, ninth dropped", d, 32'hB000_0000 + i);
        end
        hr(3, 0, d); check("R2 rx drained", d, 0);
        hr(5, 0, d); check("R2 empty rx reads zero", d, 0);
    endtask

    task automatic t_thresh();
        logic [31:0] d;
        do_reset();
        hw(2, 32'h32);
        hw(0, 32'h3E);
        hr(0, 0, d); check("R6 set wins over clear (tx request)", d, 32'h04);
        for (int i = 0; i < 3; i++) hw(4, i);
        hw(0, 32'h3E);
        hr(0, 0, d); check("R9 tx request off above threshold", d, 0);
        epush(1); epush(2);
        hw(0, 32'h3E);
        hr(0, 0, d); check("R10 rx request off below threshold", d, 0);
        epush(3);
        hr(0, 0, d); check("R10 rx request at threshold", d, 32'h08);
    endtask

    task automatic t_done_busy();
        logic [31:0] d;
        do_reset();
        hw(4, 32'h1);
        hw(2, 32'h80);
        hw(0, 32'h3E);
        hr(0, 0, d); check("R6 status clear", d, 0);
        epush(32'h55);
        edone();
        hr(0, 0, d); check("R8 R10 done with rx leftover", d, 32'h0A);
        hw(0, 32'h0);
        hr(0, 0, d); check("R6 writing zero keeps bits", d, 32'h0A);
        @(negedge clk); eng_busy = 1;
        hr(0, 0, d); check("R7 pending follows busy", d, 32'h0B);
        hw(0, 32'h1);
        hr(0, 0, d); check("R7 pending ignores w1c", d, 32'h0B);
        @(negedge clk); eng_busy = 0;
        hr(0, 0, d); check("R7 pending drops with busy", d, 32'h0A);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        do_reset();
        hw(4, 32'h1);
        hw(2, 32'h80);
        hw(0, 32'h3E);
        hw(1, 32'h1F);
        #1 check("R11 no event no irq", irq, 0);
        edone();
        hr(0, 0, d); check("R10 done with empty rx sets no request", d, 32'h02);
        check("R11 irq on enabled done", irq, 1);
        hw(1, 32'h02);
        #1 check("R11 enable bit1 does not map done", irq, 0);
        hw(1, 32'h01);
        #1 check("R11 enable bit0 maps done", irq, 1);
        hw(0, 32'h02);
        #1 check("R11 irq drops after clear", irq, 0);
    endtask

    initial begin
        t_reset();
        t_tx();
        t_rx();
        t_thresh();
        t_done_busy();
        t_irq();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule